// File: doc/BRIEF.md
# Register-Mapped Single-Frame Network Buffer

This block gives software a very small network port. It has one staging buffer for the outgoing frame and one for the incoming frame. Software reaches it through a synchronous register bus. The register bus has a 6-bit byte address, separate read and write strobes, and read data that is registered one cycle after the read strobe.

To send, software writes the frame length and then pushes the bytes one at a time through a data port. When the final byte lands, the staged frame streams out on an AXI4-Stream byte master, with tlast on its final byte. To receive, a frame arriving on an AXI4-Stream byte slave is captured whole. Software then pops it byte by byte from a second data port.

A single level interrupt is driven from an interrupt-control register with three causes:
- transmit done (bit 0)
- receive done (bit 1)
- self test (bit 31)

Software acknowledges one cause per write, following a fixed priority. The self-test cause is raised by a write and drops as a side effect of reading the register.

Top module: `pktbuf_nic`

## Requirements
- R1: A read returns its data in the cycle after `bus_rd_en`. Offset 0x00 reads 32'h5350494D. Offset 0x04 reads 32'h3054454E. Offsets 0x18 and 0x20 read 0.
- R2: After reset:
  - busy (offset 0x08, bit 0), the receive count (0x0C), the transmit count (0x10) and interrupt control (0x14) all read 0;
  - `irq` and `m_axis_tvalid` are low;
  - `s_axis_tready` is high.
- R3: A write to offset 0x10 stores the value when it is at most MAX_FRAME (1514). A larger value stores 0. Offset 0x10 reads the stored value.
- R4: Each write to offset 0x20 stores the low byte at the write pointer and then advances the pointer. When the pointer reaches the transmit count, the frame is sent: the count and the pointer return to 0, and transmit-done (bit 0 of 0x14) is set.
- R5: A sent frame leaves on the master stream in write order, with `m_axis_tlast` on its final byte only. While tvalid is high and tready is low, tdata and tlast hold their values. Writes to 0x20 made while a frame is still streaming are dropped.
- R6: While `s_axis_tready` is high, incoming bytes are stored. At the tlast beat the following happens:
  - the receive count becomes the frame length, saturating at MAX_FRAME, and bytes beyond MAX_FRAME are dropped;
  - the read pointer returns to 0;
  - receive-done (bit 1) is set;
  - busy becomes 1.
- R7: `s_axis_tready` is low whenever busy is 1 or the receive count is nonzero. In that state a new frame is refused.
- R8: A read of offset 0x1C does two things in the same access:
  - it returns the byte at the read pointer;
  - it advances the pointer and decrements the receive count.

  With a count of 0 the read returns 0 and changes nothing.
- R9: A write to 0x14 does only the first matching action:
  1. if bit 0 is set, clear transmit-done;
  2. otherwise, if bit 1 is set, clear receive-done;
  3. otherwise, if bit 31 is set, set the test bit.

  After the write, busy is 1 exactly when interrupt control is nonzero.
- R10: A read of 0x14 returns the current value and clears bit 31 in the same access.
- R11: `irq` is high exactly when interrupt control is nonzero.
- R12: Writes to offsets 0x00, 0x04, 0x08, 0x0C, 0x18 and 0x1C have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register byte offset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rd_en | input | 1 | Register read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |
| s_axis_tvalid | input | 1 | Receive stream valid |
| s_axis_tready | output | 1 | Receive stream ready |
| s_axis_tdata | input | 8 | Receive stream byte |
| s_axis_tlast | input | 1 | Receive stream end of frame |
| m_axis_tvalid | output | 1 | Transmit stream valid |
| m_axis_tready | input | 1 | Transmit stream ready |
| m_axis_tdata | output | 8 | Transmit stream byte |
| m_axis_tlast | output | 1 | Transmit stream end of frame |

## Verification
The assertions check several rules on every cycle:
- the transmit stream holds its byte while stalled;
- a receive tlast beat is followed by the interrupt, busy and a lowered tready;
- the two byte counts never pass the frame limit;
- a transmit-done acknowledge clears its bit;
- a control read clears the test bit;
- each receive pop lowers the count by one.

Some behaviour needs stimulus sequences, so only the bench scenarios can show it:
- byte order and the position of tlast;
- drop of data writes during a drain;
- the priority of one write carrying several acknowledge bits;
- refusal of a second frame;
- saturation on an oversized frame;
- the read-only offsets ignoring writes.

// File: rtl/pktbuf_nic_pkg.sv
package pktbuf_nic_pkg;

    localparam int unsigned REG_AW = 6;
    localparam int unsigned REG_DW = 32;

    localparam logic [REG_AW-1:0] OFF_ID0   = 6'h00;
    localparam logic [REG_AW-1:0] OFF_ID1   = 6'h04;
    localparam logic [REG_AW-1:0] OFF_BUSY  = 6'h08;
    localparam logic [REG_AW-1:0] OFF_RXCNT = 6'h0C;
    localparam logic [REG_AW-1:0] OFF_TXCNT = 6'h10;
    localparam logic [REG_AW-1:0] OFF_ICTL  = 6'h14;
    localparam logic [REG_AW-1:0] OFF_IINFO = 6'h18;
    localparam logic [REG_AW-1:0] OFF_RXDAT = 6'h1C;
    localparam logic [REG_AW-1:0] OFF_TXDAT = 6'h20;

    localparam logic [REG_DW-1:0] ID_WORD0 = 32'h5350_494D;
    localparam logic [REG_DW-1:0] ID_WORD1 = 32'h3054_454E;

    localparam int unsigned ICTL_TX   = 0;
    localparam int unsigned ICTL_RX   = 1;
    localparam int unsigned ICTL_TEST = 31;

    // Interrupt causes held as a compact struct; widened only at the bus.
    typedef struct packed {
        logic test;
        logic rx_done;
        logic tx_done;
    } ictl_t;

    typedef enum logic [1:0] {
        ICMD_NONE,
        ICMD_ACK_TX,
        ICMD_ACK_RX,
        ICMD_SET_TEST
    } ictl_cmd_e;

    typedef struct packed {
        logic txcnt_wr;
        logic txdat_wr;
        logic ictl_wr;
        logic ictl_rd;
        logic rxdat_rd;
    } reg_strobe_t;

    // One cause per write, lowest bit first.
    function automatic ictl_cmd_e ictl_decode(logic [REG_DW-1:0] v);
        if (v[ICTL_TX])        return ICMD_ACK_TX;
        else if (v[ICTL_RX])   return ICMD_ACK_RX;
        else if (v[ICTL_TEST]) return ICMD_SET_TEST;
        return ICMD_NONE;
    endfunction

    function automatic logic [REG_DW-1:0] ictl_word(ictl_t s);
        return {s.test, 29'b0, s.rx_done, s.tx_done};
    endfunction

    function automatic reg_strobe_t strobe_decode(logic wr, logic rd,
                                                  logic [REG_AW-1:0] a);
        reg_strobe_t s;
        s.txcnt_wr = wr && (a == OFF_TXCNT);
        s.txdat_wr = wr && (a == OFF_TXDAT);
        s.ictl_wr  = wr && (a == OFF_ICTL);
        s.ictl_rd  = rd && (a == OFF_ICTL);
        s.rxdat_rd = rd && (a == OFF_RXDAT);
        return s;
    endfunction

endpackage

// File: rtl/nic_tx_path.sv
module nic_tx_path
    import pktbuf_nic_pkg::*;
#(
    parameter int unsigned MAX_FRAME = 1514,
    localparam int unsigned CW = $clog2(MAX_FRAME + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_wr,
    input  logic [REG_DW-1:0] cnt_wdata,
    input  logic              dat_wr,
    input  logic [7:0]        dat_byte,
    output logic [CW-1:0]     tx_count,
    output logic              sent,
    output logic              m_tvalid,
    output logic [7:0]        m_tdata,
    output logic              m_tlast,
    input  logic              m_tready
);

    logic [7:0]    mem [MAX_FRAME];
    logic [CW-1:0] count_q, wptr_q, dlen_q, didx_q;
    logic          drain_q;
    logic          accept, last_write, last_beat;
    logic [CW-1:0] wptr_inc;

    assign wptr_inc   = wptr_q + CW'(1);
    assign accept     = dat_wr && !drain_q && (wptr_q < CW'(MAX_FRAME));
    assign last_write = accept && (wptr_inc == count_q);
    assign last_beat  = (didx_q == dlen_q - CW'(1));

    always_ff @(posedge clk) begin
        if (accept) mem[wptr_q] <= dat_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            wptr_q  <= '0;
            dlen_q  <= '0;
            didx_q  <= '0;
            drain_q <= 1'b0;
        end else begin
            if (cnt_wr)
                count_q <= (cnt_wdata <= REG_DW'(MAX_FRAME)) ? cnt_wdata[CW-1:0] : '0;
            if (accept) begin
                if (last_write) begin
                    count_q <= '0;
                    wptr_q  <= '0;
                    dlen_q  <= count_q;
                    didx_q  <= '0;
                    drain_q <= 1'b1;
                end else begin
                    wptr_q <= wptr_inc;
                end
            end
            if (drain_q && m_tready) begin
                if (last_beat) drain_q <= 1'b0;
                else           didx_q  <= didx_q + CW'(1);
            end
        end
    end

    assign tx_count = count_q;
    assign sent     = last_write;
    assign m_tvalid = drain_q;
    assign m_tdata  = mem[didx_q];
    assign m_tlast  = drain_q && last_beat;

endmodule

// File: rtl/nic_rx_path.sv
module nic_rx_path
    import pktbuf_nic_pkg::*;
#(
    parameter int unsigned MAX_FRAME = 1514,
    localparam int unsigned CW = $clog2(MAX_FRAME + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          pop,
    output logic [7:0]    pop_byte,
    output logic [CW-1:0] rx_count,
    output logic          commit,
    input  logic          s_tvalid,
    output logic          s_tready,
    input  logic [7:0]    s_tdata,
    input  logic          s_tlast
);

    logic [7:0]    mem [MAX_FRAME];
    logic [CW-1:0] count_q, fill_q, rptr_q;
    logic          take, store;

    assign s_tready = !hold && (count_q == '0);
    assign take     = s_tvalid && s_tready;
    assign store    = take && (fill_q < CW'(MAX_FRAME));
    assign commit   = take && s_tlast;

    always_ff @(posedge clk) begin
        if (store) mem[fill_q] <= s_tdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            fill_q  <= '0;
            rptr_q  <= '0;
        end else if (take) begin
            if (s_tlast) begin
                count_q <= store ? fill_q + CW'(1) : fill_q;
                fill_q  <= '0;
                rptr_q  <= '0;
            end else if (store) begin
                fill_q <= fill_q + CW'(1);
            end
        end else if (pop && (count_q != '0)) begin
            rptr_q  <= rptr_q + CW'(1);
            count_q <= count_q - CW'(1);
        end
    end

    assign pop_byte = (count_q != '0) ? mem[rptr_q] : 8'h00;
    assign rx_count = count_q;

endmodule

// File: rtl/nic_irq_ctl.sv
module nic_irq_ctl
    import pktbuf_nic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ictl_wr,
    input  ictl_cmd_e         ictl_cmd,
    input  logic              ictl_rd,
    input  logic              set_tx,
    input  logic              set_rx,
    output logic [REG_DW-1:0] intctl,
    output logic              busy,
    output logic              irq
);

    ictl_t cur_q, nxt;
    logic  busy_q;

    always_comb begin
        nxt = cur_q;
        if (ictl_wr) begin
            unique case (ictl_cmd)
                ICMD_ACK_TX:   nxt.tx_done = 1'b0;
                ICMD_ACK_RX:   nxt.rx_done = 1'b0;
                ICMD_SET_TEST: nxt.test    = 1'b1;
                default:       ;
            endcase
        end
        if (ictl_rd) nxt.test = 1'b0;
        if (set_tx)  nxt.tx_done = 1'b1;
        if (set_rx)  nxt.rx_done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            cur_q <= nxt;
            if (set_rx)       busy_q <= 1'b1;
            else if (ictl_wr) busy_q <= |nxt;
        end
    end

    assign intctl = ictl_word(cur_q);
    assign busy   = busy_q;
    assign irq    = |cur_q;

endmodule

// File: rtl/pktbuf_nic.sv
module pktbuf_nic
    import pktbuf_nic_pkg::*;
#(
    parameter int unsigned MAX_FRAME = 1514
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [REG_DW-1:0] bus_wdata,
    input  logic              bus_rd_en,
    output logic [REG_DW-1:0] bus_rdata,
    output logic              irq,
    input  logic              s_axis_tvalid,
    output logic              s_axis_tready,
    input  logic [7:0]        s_axis_tdata,
    input  logic              s_axis_tlast,
    output logic              m_axis_tvalid,
    input  logic              m_axis_tready,
    output logic [7:0]        m_axis_tdata,
    output logic              m_axis_tlast
);

    localparam int unsigned CW = $clog2(MAX_FRAME + 1);

    reg_strobe_t       stb;
    logic [CW-1:0]     txcnt_w, rxcnt_w;
    logic [REG_DW-1:0] intctl_w, rd_val;
    logic [7:0]        rx_byte;
    logic              busy_w, tx_sent, rx_commit;

    assign stb = strobe_decode(bus_wr_en, bus_rd_en, bus_addr);

    nic_tx_path #(.MAX_FRAME(MAX_FRAME)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .cnt_wr   (stb.txcnt_wr),
        .cnt_wdata(bus_wdata),
        .dat_wr   (stb.txdat_wr),
        .dat_byte (bus_wdata[7:0]),
        .tx_count (txcnt_w),
        .sent     (tx_sent),
        .m_tvalid (m_axis_tvalid),
        .m_tdata  (m_axis_tdata),
        .m_tlast  (m_axis_tlast),
        .m_tready (m_axis_tready)
    );

    nic_rx_path #(.MAX_FRAME(MAX_FRAME)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .hold    (busy_w),
        .pop     (stb.rxdat_rd),
        .pop_byte(rx_byte),
        .rx_count(rxcnt_w),
        .commit  (rx_commit),
        .s_tvalid(s_axis_tvalid),
        .s_tready(s_axis_tready),
        .s_tdata (s_axis_tdata),
        .s_tlast (s_axis_tlast)
    );

    nic_irq_ctl u_irq (
        .clk     (clk),
        .rst     (rst),
        .ictl_wr (stb.ictl_wr),
        .ictl_cmd(ictl_decode(bus_wdata)),
        .ictl_rd (stb.ictl_rd),
        .set_tx  (tx_sent),
        .set_rx  (rx_commit),
        .intctl  (intctl_w),
        .busy    (busy_w),
        .irq     (irq)
    );

    always_comb begin
        unique case (bus_addr)
            OFF_ID0:   rd_val = ID_WORD0;
            OFF_ID1:   rd_val = ID_WORD1;
            OFF_BUSY:  rd_val = {31'b0, busy_w};
            OFF_RXCNT: rd_val = REG_DW'(rxcnt_w);
            OFF_TXCNT: rd_val = REG_DW'(txcnt_w);
            OFF_ICTL:  rd_val = intctl_w;
            OFF_RXDAT: rd_val = {24'b0, rx_byte};
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)            bus_rdata <= '0;
        else if (bus_rd_en) bus_rdata <= rd_val;
    end

endmodule

// File: rtl/pktbuf_nic_chk.sv
module pktbuf_nic_chk
    import pktbuf_nic_pkg::*;
#(
    parameter int unsigned MAX_FRAME = 1514,
    parameter int unsigned CW = 11
) (
    input logic              clk,
    input logic              rst,
    input logic [REG_AW-1:0] bus_addr,
    input logic              bus_wr_en,
    input logic [REG_DW-1:0] bus_wdata,
    input logic              bus_rd_en,
    input logic              irq,
    input logic              s_tvalid,
    input logic              s_tready,
    input logic              s_tlast,
    input logic              m_tvalid,
    input logic              m_tready,
    input logic [7:0]        m_tdata,
    input logic              m_tlast,
    input logic [REG_DW-1:0] intctl,
    input logic              busy,
    input logic [CW-1:0]     tx_count,
    input logic [CW-1:0]     rx_count
);

    a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

    a_r6_commit_flags: assert property (@(posedge clk) disable iff (rst)
        s_tvalid && s_tready && s_tlast |=> irq && busy && intctl[ICTL_RX]);

    a_r7_ready_drop: assert property (@(posedge clk) disable iff (rst)
        s_tvalid && s_tready && s_tlast |=> !s_tready);

    a_r3_tx_bound: assert property (@(posedge clk) disable iff (rst)
        tx_count <= CW'(MAX_FRAME));

    a_r6_rx_bound: assert property (@(posedge clk) disable iff (rst)
        rx_count <= CW'(MAX_FRAME));

    a_r9_tx_ack: assert property (@(posedge clk) disable iff (rst)
        bus_wr_en && bus_addr == OFF_ICTL && bus_wdata[ICTL_TX] |=> !intctl[ICTL_TX]);

    a_r10_test_clear: assert property (@(posedge clk) disable iff (rst)
        bus_rd_en && !bus_wr_en && bus_addr == OFF_ICTL |=> !intctl[ICTL_TEST]);

    a_r8_pop_dec: assert property (@(posedge clk) disable iff (rst)
        bus_rd_en && !bus_wr_en && bus_addr == OFF_RXDAT && rx_count != '0
        |=> rx_count == $past(rx_count) - CW'(1));

endmodule

bind pktbuf_nic pktbuf_nic_chk #(.MAX_FRAME(MAX_FRAME), .CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata),
    .bus_rd_en(bus_rd_en),
    .irq      (irq),
    .s_tvalid (s_axis_tvalid),
    .s_tready (s_axis_tready),
    .s_tlast  (s_axis_tlast),
    .m_tvalid (m_axis_tvalid),
    .m_tready (m_axis_tready),
    .m_tdata  (m_axis_tdata),
    .m_tlast  (m_axis_tlast),
    .intctl   (intctl_w),
    .busy     (busy_w),
    .tx_count (txcnt_w),
    .rx_count (rxcnt_w)
);

// File: tb/pktbuf_nic_bench.sv
`timescale 1ns/1ps
module pktbuf_nic_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  bus_addr;
    logic        bus_wr_en, bus_rd_en;
    logic [31:0] bus_wdata, bus_rdata;
    logic        irq;
    logic        s_tvalid, s_tready, s_tlast;
    logic [7:0]  s_tdata;
    logic        m_tvalid, m_tready, m_tlast;
    logic [7:0]  m_tdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] got_data [0:15];
    logic       got_last [0:15];
    int         got_n;

    always #2 clk = ~clk;

    pktbuf_nic u_pktbuf_nic (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata),
        .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata), .irq(irq),
        .s_axis_tvalid(s_tvalid), .s_axis_tready(s_tready),
        .s_axis_tdata(s_tdata), .s_axis_tlast(s_tlast),
        .m_axis_tvalid(m_tvalid), .m_axis_tready(m_tready),
        .m_axis_tdata(m_tdata), .m_axis_tlast(m_tlast)
    );

    function automatic logic [7:0] pat(int i, int seed);
        return 8'(i * 7 + seed);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic send_frame(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            s_tvalid = 1'b1; s_tdata = pat(i, seed); s_tlast = (i == n - 1);
            while (!s_tready) @(negedge clk);
            @(negedge clk);
        end
        s_tvalid = 1'b0; s_tlast = 1'b0;
    endtask

    task automatic collect();
        int guard;
        got_n = 0;
        guard = 0;
        m_tready = 1'b1;
        while (guard < 64) begin
            if (m_tvalid && got_n < 16) begin
                got_data[got_n] = m_tdata;
                got_last[got_n] = m_tlast;
                got_n++;
                if (m_tlast) begin
                    @(negedge clk);
                    break;
                end
            end
            @(negedge clk);
            guard++;
        end
        m_tready = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(6'h08, v); chk("R2 busy", v, 0);
        rd(6'h0C, v); chk("R2 rx count", v, 0);
        rd(6'h10, v); chk("R2 tx count", v, 0);
        rd(6'h14, v); chk("R2 intctl", v, 0);
        chk("R2 irq", irq, 0);
        chk("R2 s_tready", s_tready, 1);
        chk("R2 m_tvalid", m_tvalid, 0);
    endtask

    task automatic t_ident();
        logic [31:0] v;
        rd(6'h00, v); chk("R1 id0", v, 32'h5350494D);
        rd(6'h04, v); chk("R1 id1", v, 32'h3054454E);
        rd(6'h18, v); chk("R1 info", v, 0);
        rd(6'h20, v); chk("R1 txdat read", v, 0);
    endtask

    task automatic t_txcount();
        logic [31:0] v;
        wr(6'h10, 2000); rd(6'h10, v); chk("R3 oversize", v, 0);
        wr(6'h10, 1515); rd(6'h10, v); chk("R3 limit+1", v, 0);
        wr(6'h10, 1514); rd(6'h10, v); chk("R3 limit", v, 1514);
        wr(6'h10, 0);    rd(6'h10, v); chk("R3 zero", v, 0);
    endtask

    task automatic t_tx();
        logic [31:0] v;
        m_tready = 1'b0;
        wr(6'h10, 4);
        for (int i = 0; i < 4; i++) wr(6'h20, 32'hABCD_EF00 | 32'(pat(i, 9)));
        chk("R5 valid", m_tvalid, 1);
        chk("R5 first byte", m_tdata, pat(0, 9));
        rd(6'h10, v); chk("R4 count cleared", v, 0);
        rd(6'h14, v); chk("R4 txdone", v, 1);
        chk("R11 irq on", irq, 1);
        repeat (3) @(negedge clk);
        chk("R5 held", {m_tvalid, m_tdata}, {1'b1, pat(0, 9)});
        wr(6'h20, 32'h77);
        collect();
        chk("R5 beats", got_n, 4);
        for (int i = 0; i < 4; i++) begin
            chk("R5 order", got_data[i], pat(i, 9));
            chk("R5 tlast", got_last[i], i == 3);
        end
        chk("R5 idle", m_tvalid, 0);
        wr(6'h14, 1);
        rd(6'h14, v); chk("R9 tx ack", v, 0);
        chk("R11 irq off", irq, 0);
        wr(6'h10, 1);
        wr(6'h20, 32'h5C);
        collect();
        chk("R5 dropped write", {24'b0, got_data[0]}, 32'h5C);
        chk("R5 single tlast", {got_n[7:0], 7'b0, got_last[0]}, {8'd1, 8'd1});
        wr(6'h14, 1);
    endtask

    task automatic t_rx();
        logic [31:0] v;
        send_frame(5, 8'h30);
        rd(6'h0C, v); chk("R6 count", v, 5);
        rd(6'h14, v); chk("R6 rxdone", v, 2);
        rd(6'h08, v); chk("R6 busy", v, 1);
        chk("R11 irq rx", irq, 1);
        chk("R7 ready low", s_tready, 0);
        s_tvalid = 1'b1; s_tdata = 8'hEE; s_tlast = 1'b1;
        repeat (5) @(negedge clk);
        chk("R7 refused ready", s_tready, 0);
        s_tvalid = 1'b0; s_tlast = 1'b0;
        rd(6'h0C, v); chk("R7 count kept", v, 5);
        wr(6'h0C, 0); wr(6'h1C, 32'hFF); wr(6'h08, 0); wr(6'h00, 0);
        wr(6'h04, 0); wr(6'h18, 7);
        rd(6'h0C, v); chk("R12 rx count", v, 5);
        rd(6'h08, v); chk("R12 busy", v, 1);
        rd(6'h00, v); chk("R12 id0", v, 32'h5350494D);
        rd(6'h04, v); chk("R12 id1", v, 32'h3054454E);
        rd(6'h18, v); chk("R12 info", v, 0);
        wr(6'h14, 2);
        rd(6'h14, v); chk("R9 rx ack", v, 0);
        rd(6'h08, v); chk("R9 busy clear", v, 0);
        chk("R7 ready while unread", s_tready, 0);
        for (int i = 0; i < 5; i++) begin
            rd(6'h1C, v); chk("R8 pop byte", v, 32'(pat(i, 8'h30)));
        end
        rd(6'h0C, v); chk("R8 count drained", v, 0);
        rd(6'h1C, v); chk("R8 empty pop", v, 0);
        rd(6'h0C, v); chk("R8 empty unchanged", v, 0);
        chk("R7 ready back", s_tready, 1);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        wr(6'h10, 1); wr(6'h20, 32'h11); collect();
        send_frame(1, 8'h44);
        rd(6'h14, v); chk("R9 both set", v, 3);
        wr(6'h14, 32'h8000_0003);
        rd(6'h14, v); chk("R9 bit0 first", v, 2);
        rd(6'h08, v); chk("R9 busy stays", v, 1);
        wr(6'h14, 32'h8000_0002);
        rd(6'h14, v); chk("R9 bit1 next", v, 0);
        rd(6'h08, v); chk("R9 busy drops", v, 0);
        wr(6'h14, 32'h8000_0000);
        rd(6'h08, v); chk("R9 test busy", v, 1);
        chk("R11 irq test", irq, 1);
        rd(6'h14, v); chk("R10 test read", v, 32'h8000_0000);
        rd(6'h14, v); chk("R10 test cleared", v, 0);
        chk("R11 irq after read", irq, 0);
        wr(6'h14, 0);
        rd(6'h08, v); chk("R9 ack busy", v, 0);
        rd(6'h1C, v); chk("R8 single pop", v, 32'h44);
    endtask

    task automatic t_full();
        logic [31:0] v;
        int bad;
        send_frame(1516, 3);
        rd(6'h0C, v); chk("R6 saturate", v, 1514);
        wr(6'h14, 2);
        bad = 0;
        for (int i = 0; i < 1514; i++) begin
            rd(6'h1C, v);
            if (v !== 32'(pat(i, 3)) && bad == 0) begin
                bad = 1;
                chk("R6 full frame byte", v, 32'(pat(i, 3)));
            end
        end
        if (bad == 0) chk("R6 full frame bytes", 0, 0);
        rd(6'h0C, v); chk("R8 full drained", v, 0);
        chk("R7 ready after full", s_tready, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_addr = '0; bus_wr_en = 1'b0; bus_rd_en = 1'b0; bus_wdata = '0;
        s_tvalid = 1'b0; s_tdata = '0; s_tlast = 1'b0; m_tready = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ident();
        t_txcount();
        t_tx();
        t_rx();
        t_priority();
        t_full();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule